// File: doc/BRIEF.md
# Serial Transmitter with Break Field Generation

This block is the transmit half of an asynchronous serial port that can also emit the long low pulse used to open a LIN header. Software controls it through a power switch, a transmit-enable switch, a write-one break request and a 3-bit break length. Bytes go out as 8N1 frames from a one-entry holding buffer. Every bit period lasts from one baud tick to the next, and the ticks come from an external prescaler as one-clock pulses.

A break request takes over the line at the next frame boundary and holds it low for 13 plus the length code bit periods. When it ends, the request flag clears itself and a one-clock completion pulse is raised. The line then returns to high idle and waits for the next buffered byte or the next break request.

Top module: `lin_brk_tx`

## Requirements
- R1: While `pwr_en` is 0, `txd` is 1, `busy` is 0 and `brk_pend` is 0 from the next clock on. Any field in progress is abandoned, and byte writes and break requests are ignored.
- R2: Byte writes and break requests made while `tx_en` is 0 are ignored. Setting `tx_en` afterwards sends nothing.
- R3: A break drives `txd` low for exactly 13 + `brk_len` bit periods, where code 0 gives 13 and code 7 gives 20. The length is captured when the break starts.
- R4: In the clock where a break ends, `brk_pend` clears, `busy` falls, `txd` returns to 1 and `done_irq` is 1.
- R5: After a break, `txd` stays 1 and `busy` stays 0 until a byte is written or another break is requested.
- R6: A byte goes out as one low start bit, then the eight data bits least significant first, then one high stop bit. Each bit lasts one bit period.
- R7: `done_irq` is raised in the clock where the stop bit of a frame ends.
- R8: A break requested during a frame waits until that frame has finished. The frame goes out unchanged.
- R9: When a byte write and a break request arrive in the same clock, the break is sent first and the byte follows it.
- R10: A field (break or frame) starts only on a baud tick. `txd` changes only after a tick, and `busy` stays 1 for the whole field.
- R11: `done_irq` is high for one clock per completed field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_en | input | 1 | Power switch; 0 resets the line and clears all requests |
| tx_en | input | 1 | Transmit enable |
| brk_start | input | 1 | Write-one break request |
| brk_len | input | LEN_W | Break length code; the break lasts 13 + code bit periods |
| wr_valid | input | 1 | Writes `wr_data` into the holding buffer |
| wr_data | input | DATA_W | Byte to transmit |
| baud_tick | input | 1 | One-clock pulse marking each bit-period boundary |
| txd | output | 1 | Serial line, high when idle |
| busy | output | 1 | High while a break or frame is on the line |
| brk_pend | output | 1 | Break request flag; clears itself when the break ends |
| done_irq | output | 1 | One-clock completion pulse |

## Verification
On every cycle, the assertions check the power-off state, that the line is held low throughout a break, and that the break length matches the captured code, using a tick counter in the checker. They also check that fields start on a tick, that the line holds between ticks, that a break starts only outside a frame, and that the completion pulse is one clock wide and follows a field. Only the directed scenarios can show that the decoded frame bits carry the written byte in the right order, and that writes are really ignored while transmission is disabled. They also show that a break waits behind a frame and that a simultaneous byte follows the break, both of which depend on sequences of events across fields.

// File: rtl/lin_tx_pkg.sv
package lin_tx_pkg;

  localparam int BRK_BASE = 13;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BRK  = 2'd1,
    ST_FRM  = 2'd2
  } tx_state_e;

  // Bit periods of a break for a given length code.
  function automatic int brk_periods(input int code);
    return BRK_BASE + code;
  endfunction

  // Bit periods of one data frame: start + data + stop.
  function automatic int frame_periods(input int data_w);
    return data_w + 2;
  endfunction

  // Longest field the bit counter must cover.
  function automatic int field_span(input int len_w, input int data_w);
    int b;
    int f;
    b = brk_periods((1 << len_w) - 1);
    f = frame_periods(data_w);
    return (b > f) ? b : f;
  endfunction

endpackage

// File: rtl/lin_tx_req.sv
module lin_tx_req #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              accept,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              brk_set,
  input  logic              take_byte,
  input  logic              brk_done,
  output logic              byte_full,
  output logic [DATA_W-1:0] byte_data,
  output logic              brk_pend
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      byte_full <= 1'b0;
      byte_data <= '0;
    end else if (accept && wr_valid) begin
      byte_full <= 1'b1;
      byte_data <= wr_data;
    end else if (take_byte) begin
      byte_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      brk_pend <= 1'b0;
    end else if (brk_done) begin
      brk_pend <= 1'b0;
    end else if (accept && brk_set) begin
      brk_pend <= 1'b1;
    end
  end

endmodule

// File: rtl/lin_tx_ticker.sv
module lin_tx_ticker #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic             active,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  assign last = active && tick && (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr || start || last) begin
      cnt <= '0;
    end else if (active && tick) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/lin_tx_fsm.sv
module lin_tx_fsm
  import lin_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 3,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic              tick,
  input  logic              brk_pend,
  input  logic              byte_full,
  input  logic [DATA_W-1:0] byte_data,
  input  logic [LEN_W-1:0]  brk_len,
  input  logic              field_end,
  output tx_state_e         state,
  output logic              start_brk,
  output logic              start_frm,
  output logic [CNT_W-1:0]  limit,
  output logic              txd,
  output logic              done_irq
);

  localparam int REM_W = DATA_W + 1;

  logic [REM_W-1:0] rem;
  logic             idle_slot;

  assign idle_slot = (state == ST_IDLE) && run && tick;
  assign start_brk = idle_slot && brk_pend;
  assign start_frm = idle_slot && !brk_pend && byte_full;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      state    <= ST_IDLE;
      rem      <= '1;
      limit    <= '0;
      txd      <= 1'b1;
      done_irq <= 1'b0;
    end else begin
      done_irq <= field_end;
      if (start_brk) begin
        state <= ST_BRK;
        limit <= CNT_W'(brk_periods(int'(brk_len)));
        txd   <= 1'b0;
      end else if (start_frm) begin
        state <= ST_FRM;
        limit <= CNT_W'(frame_periods(DATA_W));
        rem   <= {1'b1, byte_data};
        txd   <= 1'b0;
      end else if (field_end) begin
        state <= ST_IDLE;
        txd   <= 1'b1;
      end else if ((state == ST_FRM) && tick) begin
        txd <= rem[0];
        rem <= {1'b1, rem[REM_W-1:1]};
      end
    end
  end

endmodule

// File: rtl/lin_brk_tx.sv
module lin_brk_tx
  import lin_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_en,
  input  logic              tx_en,
  input  logic              brk_start,
  input  logic [LEN_W-1:0]  brk_len,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              baud_tick,
  output logic              txd,
  output logic              busy,
  output logic              brk_pend,
  output logic              done_irq
);

  localparam int CNT_W = $clog2(field_span(LEN_W, DATA_W) + 1);

  tx_state_e         state;
  logic              clr;
  logic              run;
  logic              start_brk;
  logic              start_frm;
  logic              field_end;
  logic              brk_done;
  logic              brk_active;
  logic              frm_active;
  logic              byte_full;
  logic [DATA_W-1:0] byte_data;
  logic [CNT_W-1:0]  limit;

  assign clr        = !pwr_en;
  assign run        = pwr_en && tx_en;
  assign brk_active = (state == ST_BRK);
  assign frm_active = (state == ST_FRM);
  assign busy       = brk_active || frm_active;
  assign brk_done   = field_end && brk_active;

  lin_tx_req #(.DATA_W(DATA_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .accept    (run),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .brk_set   (brk_start),
    .take_byte (start_frm),
    .brk_done  (brk_done),
    .byte_full (byte_full),
    .byte_data (byte_data),
    .brk_pend  (brk_pend)
  );

  lin_tx_ticker #(.CNT_W(CNT_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .start  (start_brk || start_frm),
    .active (busy),
    .tick   (baud_tick),
    .limit  (limit),
    .last   (field_end)
  );

  lin_tx_fsm #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .run       (run),
    .tick      (baud_tick),
    .brk_pend  (brk_pend),
    .byte_full (byte_full),
    .byte_data (byte_data),
    .brk_len   (brk_len),
    .field_end (field_end),
    .state     (state),
    .start_brk (start_brk),
    .start_frm (start_frm),
    .limit     (limit),
    .txd       (txd),
    .done_irq  (done_irq)
  );

endmodule

// File: rtl/lin_brk_tx_chk.sv
module lin_brk_tx_chk #(
  parameter int LEN_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_en,
  input logic             baud_tick,
  input logic [LEN_W-1:0] brk_len,
  input logic             txd,
  input logic             busy,
  input logic             brk_pend,
  input logic             done_irq,
  input logic             start_brk,
  input logic             brk_active,
  input logic             frm_active,
  input logic             brk_done
);

  logic [7:0] chk_ticks;
  logic [7:0] chk_exp;

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_en) begin
      chk_ticks <= 8'd0;
      chk_exp   <= 8'd0;
    end else if (start_brk) begin
      chk_ticks <= 8'd0;
      chk_exp   <= 8'd13 + 8'(brk_len);
    end else if (brk_active && baud_tick) begin
      chk_ticks <= chk_ticks + 8'd1;
    end
  end

  assert_off_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> (txd && !busy && !brk_pend));

  assert_brk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    brk_active |-> !txd);

  assert_brk_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    brk_done |-> (chk_ticks == chk_exp - 8'd1));

  assert_brk_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(brk_pend) && $past(pwr_en)) |-> (done_irq && !busy && txd));

  assert_irq_after_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> $past(busy));

  assert_brk_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_brk |-> !frm_active);

  assert_start_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(baud_tick));

  assert_bit_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && !$past(baud_tick)) |-> $stable(txd));

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

endmodule

bind lin_brk_tx lin_brk_tx_chk #(.LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_en     (pwr_en),
  .baud_tick  (baud_tick),
  .brk_len    (brk_len),
  .txd        (txd),
  .busy       (busy),
  .brk_pend   (brk_pend),
  .done_irq   (done_irq),
  .start_brk  (start_brk),
  .brk_active (brk_active),
  .frm_active (frm_active),
  .brk_done   (brk_done)
);

// File: tb/lin_brk_tx_test.sv
module lin_brk_tx_test;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int FBITS      = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_en = 1'b0;
  logic       tx_en = 1'b0;
  logic       brk_start = 1'b0;
  logic [2:0] brk_len = 3'd0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       baud_tick = 1'b0;
  logic       txd;
  logic       busy;
  logic       brk_pend;
  logic       done_irq;

  int checks = 0;
  int errors = 0;
  int tdiv = 0;

  lin_brk_tx uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_en    (pwr_en),
    .tx_en     (tx_en),
    .brk_start (brk_start),
    .brk_len   (brk_len),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .baud_tick (baud_tick),
    .txd       (txd),
    .busy      (busy),
    .brk_pend  (brk_pend),
    .done_irq  (done_irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    tdiv = (tdiv == DIV - 1) ? 0 : tdiv + 1;
    baud_tick = (tdiv == DIV - 1);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic request_break(input logic [2:0] len);
    @(negedge clk);
    brk_len   = len;
    brk_start = 1'b1;
    @(negedge clk);
    brk_start = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_data  = d;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_low(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (txd === 1'b0) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  // Measures a break on the line and the completion that follows it.
  task automatic measure_break(input int len, input string tag);
    bit seen;
    int n;
    int nbusy;
    wait_low(seen);
    chk(seen, {tag, " R3 break starts"}, 0, 1);
    n = 0;
    nbusy = 0;
    while (txd === 1'b0 && n < 1000) begin
      if (busy !== 1'b1) nbusy++;
      n++;
      @(negedge clk);
    end
    chk(n == (13 + len) * DIV, {tag, " R3 low samples"}, n, (13 + len) * DIV);
    chk(nbusy == 0, {tag, " R10 busy during break"}, nbusy, 0);
    chk(done_irq === 1'b1, {tag, " R4 irq at break end"}, done_irq, 1);
    chk(brk_pend === 1'b0 && busy === 1'b0, {tag, " R4 flag and busy clear"},
        {brk_pend, busy}, 0);
    @(negedge clk);
    chk(done_irq === 1'b0, {tag, " R11 irq one clock"}, done_irq, 0);
  endtask

  // Captures one frame from its start bit; optionally asks for a break mid-frame.
  task automatic capture_frame(input logic [7:0] exp, input bit inject, input string tag);
    bit seen;
    logic s[0:FBITS*DIV];
    logic [7:0] got;
    int early_irq;
    int nbusy;
    wait_low(seen);
    chk(seen, {tag, " R6 start seen"}, 0, 1);
    early_irq = 0;
    nbusy = 0;
    s[0] = txd;
    for (int i = 1; i <= FBITS * DIV; i++) begin
      if (done_irq === 1'b1) early_irq++;
      if (busy !== 1'b1) nbusy++;
      if (inject && i == 2 * DIV) begin
        brk_len   = 3'd5;
        brk_start = 1'b1;
      end
      if (inject && i == 2 * DIV + 1) brk_start = 1'b0;
      @(negedge clk);
      s[i] = txd;
    end
    for (int b = 0; b < 8; b++) got[b] = s[(b + 1) * DIV + DIV / 2];
    chk(s[DIV / 2] === 1'b0, {tag, " R6 start bit"}, s[DIV / 2], 0);
    chk(got === exp, {tag, " R6 data LSB first"}, got, exp);
    chk(s[9 * DIV + DIV / 2] === 1'b1, {tag, " R6 stop bit"}, s[9 * DIV + DIV / 2], 1);
    chk(nbusy == 0, {tag, " R10 busy during frame"}, nbusy, 0);
    chk(done_irq === 1'b1 && early_irq == 0, {tag, " R7 irq after stop"},
        done_irq, 1);
  endtask

  task automatic t_reset();
    chk(txd === 1'b1 && busy === 1'b0, "R1 reset line idle", {txd, busy}, 2);
    chk(brk_pend === 1'b0 && done_irq === 1'b0, "R1 reset flags", {brk_pend, done_irq}, 0);
  endtask

  task automatic t_disabled();
    int bad;
    pwr_en = 1'b1;
    tx_en  = 1'b0;
    write_byte(8'h5A);
    request_break(3'd1);
    bad = 0;
    for (int i = 0; i < 20 * DIV; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || busy !== 1'b0 || brk_pend !== 1'b0) bad++;
    end
    chk(bad == 0, "R2 nothing while disabled", bad, 0);
    tx_en = 1'b1;
    bad = 0;
    for (int i = 0; i < 20 * DIV; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || busy !== 1'b0) bad++;
    end
    chk(bad == 0, "R2 ignored requests stay dropped", bad, 0);
  endtask

  task automatic t_break(input logic [2:0] len);
    request_break(len);
    measure_break(int'(len), "brk");
  endtask

  task automatic t_idle_after_break();
    int bad;
    bad = 0;
    for (int i = 0; i < 16 * DIV; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || busy !== 1'b0 || done_irq !== 1'b0) bad++;
    end
    chk(bad == 0, "R5 idle after break", bad, 0);
  endtask

  task automatic t_frame(input logic [7:0] d);
    write_byte(d);
    capture_frame(d, 1'b0, "frame");
    @(negedge clk);
    chk(done_irq === 1'b0, "R11 frame irq one clock", done_irq, 0);
  endtask

  task automatic t_break_in_frame();
    write_byte(8'h3C);
    capture_frame(8'h3C, 1'b1, "R8 frame intact");
    chk(brk_pend === 1'b1, "R8 request held", brk_pend, 1);
    measure_break(5, "R8 break after frame");
  endtask

  task automatic t_simultaneous();
    @(negedge clk);
    wr_data   = 8'hC3;
    wr_valid  = 1'b1;
    brk_len   = 3'd2;
    brk_start = 1'b1;
    @(negedge clk);
    wr_valid  = 1'b0;
    brk_start = 1'b0;
    measure_break(2, "R9 break first");
    capture_frame(8'hC3, 1'b0, "R9 byte after");
  endtask

  task automatic t_power_off();
    bit seen;
    int bad;
    request_break(3'd7);
    wait_low(seen);
    chk(seen, "R1 break begun", 0, 1);
    repeat (10) @(negedge clk);
    pwr_en = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1 && busy === 1'b0 && brk_pend === 1'b0, "R1 power off abort",
        {txd, busy, brk_pend}, 4);
    write_byte(8'h99);
    pwr_en = 1'b1;
    bad = 0;
    for (int i = 0; i < 15 * DIV; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || busy !== 1'b0) bad++;
    end
    chk(bad == 0, "R1 write while off ignored", bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_break(3'd0);
    t_break(3'd7);
    t_break(3'd3);
    t_idle_after_break();
    t_frame(8'hA5);
    t_frame(8'h01);
    t_frame(8'h80);
    t_frame(8'hFF);
    t_frame(8'h00);
    t_break_in_frame();
    t_simultaneous();
    t_power_off();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule